// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the timing enables for a serial transmitter and receiver. It picks one of three clock sources: the system clock itself, the system clock divided by a fixed prescaler, or an external serial clock pin. A programmable 16-bit divisor then divides the chosen source to make a receiver sampling tick. In asynchronous operation a post-divider then turns that tick into a bit-rate tick. The post-divider divides by 16, or by 8 when the oversampling bit is set. In synchronous operation the sampling tick is used as the bit-rate tick directly.

Both outputs are single-cycle enable pulses in the system clock domain. The external pin is never used as a clock. It passes through a two-flop synchroniser, and each rising edge becomes a one-cycle enable. The configuration comes in on plain input ports. A change to any of it restarts the counters, so no period is ever emitted partly on old settings. With the reset configuration of all zeros, the block stays idle.

Top module: `baud_tick_gen`

## Requirements
- R1: With source select 0 (system clock) and divisor cd >= 1, samp_tick pulses exactly once every cd clock cycles.
- R2: With source select 1 (prescaled clock, PRE_DIV = 8), samp_tick pulses exactly once every 8*cd clock cycles.
- R3: With source select 3 (external pin), samp_tick pulses once for every cd synchronised rising edges of ext_clk, and two sampling pulses are never in adjacent cycles. The pin must stay high and stay low for more than one clock cycle, and its frequency must be at most one third of the clock.
- R4: With cd = 0, neither samp_tick nor baud_tick ever pulses.
- R5: With cd = 1, the divider is bypassed and every source enable is a sampling pulse. With select 0 this gives a sampling pulse every cycle and a fastest baud tick of one per 8 cycles.
- R6: The reserved select value 2 produces no samp_tick and no baud_tick pulses, whatever the value of cd.
- R7: With sync_mode = 0, baud_tick pulses once for every 16 sampling pulses when over = 0, and once for every 8 when over = 1. Every baud pulse falls in a cycle that also carries a sampling pulse.
- R8: With sync_mode = 1, baud_tick equals samp_tick in every cycle.
- R9: Any change to cd, the source select, over or sync_mode suppresses both outputs in the cycle it is seen and clears all counters. With select 0, the first sampling pulse then comes exactly cd cycles after the change, and the first baud pulse exactly cd*8 or cd*16 cycles after it.
- R10: While rst is high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source select: 0 system clock, 1 prescaled clock, 2 reserved, 3 external pin |
| cd | input | 16 | Main divisor (0 = off, 1 = bypass) |
| over | input | 1 | Oversampling select: 0 divides by 16, 1 divides by 8 |
| sync_mode | input | 1 | 1 skips the post-divider |
| ext_clk | input | 1 | External serial clock pin, asynchronous |
| samp_tick | output | 1 | One-cycle receiver sampling enable |
| baud_tick | output | 1 | One-cycle bit-rate enable |

## Verification
A divider counter that holds a wrong value shows up as an uneven gap between sampling pulses. This is visible within cd source enables, at most a few hundred cycles at the configurations swept. A wrong post-divider count shows as a baud gap other than 8 or 16 sampling periods, which appears within the second baud period. A missed restart is caught at the ports because the first pulse after a configuration change lands at the wrong offset from that change. A broken select or idle decode shows as pulses appearing in a window where none may appear.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;

    localparam int CD_W = 16;

    typedef enum logic [1:0] {
        SRC_SYS = 2'd0,
        SRC_PRE = 2'd1,
        SRC_RSV = 2'd2,
        SRC_EXT = 2'd3
    } src_sel_e;

    typedef struct packed {
        src_sel_e        sel;
        logic [CD_W-1:0] cd;
        logic            over;
        logic            sync_mode;
    } baud_cfg_t;

    // Last count value of the post-divider before it wraps (7 or 15)
    function automatic logic [3:0] post_last(input logic over);
        return over ? 4'd7 : 4'd15;
    endfunction

endpackage

// File: rtl/baud_src_sel.sv
`timescale 1ns/1ps
module baud_src_sel
    import baud_pkg::*;
#(
    parameter int PRE_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  src_sel_e sel,
    input  logic     ext_clk,
    output logic     src_en
);
    localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    // synchroniser chain plus one history flop for edge detection
    logic [SYNC_STAGES:0] sync_sh;
    logic                 ext_rise;

    always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SYNC_STAGES-1:0], ext_clk};
    end

    assign ext_rise = sync_sh[SYNC_STAGES-1] & ~sync_sh[SYNC_STAGES];

    // fixed prescaler
    logic [PW-1:0] pre_cnt;
    logic          pre_tick;

    assign pre_tick = (pre_cnt == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)  pre_cnt <= '0;
        else if (pre_tick)   pre_cnt <= '0;
        else                 pre_cnt <= pre_cnt + 1'b1;
    end

    always_comb begin
        case (sel)
            SRC_SYS: src_en = 1'b1;
            SRC_PRE: src_en = pre_tick;
            SRC_EXT: src_en = ext_rise;
            default: src_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/baud_cd_div.sv
`timescale 1ns/1ps
module baud_cd_div
    import baud_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            src_en,
    input  logic [CD_W-1:0] cd,
    output logic            samp_tick
);
    logic [CD_W-1:0] cnt;
    logic [CD_W-1:0] cd_last;
    logic            cd_off;
    logic            cd_bypass;
    logic            hit;

    assign cd_last   = cd - 1'b1;
    assign cd_off    = (cd == '0);
    assign cd_bypass = (cd == CD_W'(1));
    assign hit       = src_en && !cd_off && (cd_bypass || cnt == cd_last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (src_en && !cd_off && !cd_bypass) begin
            if (cnt >= cd_last) cnt <= '0;
            else                cnt <= cnt + 1'b1;
        end
    end

    assign samp_tick = hit && !restart;

endmodule

// File: rtl/baud_post_div.sv
`timescale 1ns/1ps
module baud_post_div
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic samp_tick,
    input  logic over,
    input  logic sync_mode,
    output logic baud_tick
);
    logic [3:0] pcnt;
    logic [3:0] plast;
    logic       wrap;

    assign plast = post_last(over);
    assign wrap  = (pcnt >= plast);

    always_ff @(posedge clk) begin
        if (rst || restart || sync_mode) begin
            pcnt <= '0;
        end else if (samp_tick) begin
            if (wrap) pcnt <= '0;
            else      pcnt <= pcnt + 1'b1;
        end
    end

    assign baud_tick = samp_tick && (sync_mode || wrap);

endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int PRE_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  src_sel,
    input  logic [15:0] cd,
    input  logic        over,
    input  logic        sync_mode,
    input  logic        ext_clk,
    output logic        samp_tick,
    output logic        baud_tick
);
    baud_cfg_t cfg_now;
    baud_cfg_t cfg_q;
    logic      restart;
    logic      src_en;
    logic      samp_raw;
    logic      baud_raw;

    assign cfg_now = '{sel: src_sel_e'(src_sel), cd: cd, over: over, sync_mode: sync_mode};

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_now;
    end

    assign restart = (cfg_now != cfg_q);

    baud_src_sel #(
        .PRE_DIV    (PRE_DIV),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .sel    (cfg_now.sel),
        .ext_clk(ext_clk),
        .src_en (src_en)
    );

    baud_cd_div u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .src_en   (src_en),
        .cd       (cfg_now.cd),
        .samp_tick(samp_raw)
    );

    baud_post_div u_post (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .samp_tick(samp_raw),
        .over     (cfg_now.over),
        .sync_mode(cfg_now.sync_mode),
        .baud_tick(baud_raw)
    );

    assign samp_tick = samp_raw && !rst;
    assign baud_tick = baud_raw && !rst;

endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  src_sel,
    input logic [15:0] cd,
    input logic        over,
    input logic        sync_mode,
    input logic        ext_clk,
    input logic        samp_tick,
    input logic        baud_tick
);
    logic unused_ok;
    assign unused_ok = ext_clk;

    assert_ext_not_adjacent_R3: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd3 && cd == 16'd1 && samp_tick) |=> !samp_tick);

    assert_cd_zero_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (cd == 16'd0) |-> (!samp_tick && !baud_tick));

    assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd2) |-> (!samp_tick && !baud_tick));

    assert_baud_on_samp_R7: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> samp_tick);

    assert_sync_follow_R8: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> (baud_tick == samp_tick));

    assert_change_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (cd != $past(cd) || src_sel != $past(src_sel) ||
         over != $past(over) || sync_mode != $past(sync_mode))
        |-> (!samp_tick && !baud_tick));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> (!samp_tick && !baud_tick));

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (.*);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  src_sel = 2'd0;
    logic [15:0] cd = 16'd0;
    logic        over = 1'b0;
    logic        sync_mode = 1'b0;
    logic        ext_clk = 1'b0;
    logic        samp_tick;
    logic        baud_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    baud_tick_gen u_baud_tick_gen (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .cd       (cd),
        .over     (over),
        .sync_mode(sync_mode),
        .ext_clk  (ext_clk),
        .samp_tick(samp_tick),
        .baud_tick(baud_tick)
    );

    // external clock: 6 system cycles per period, 3 high and 3 low
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic [15:0] d,
                           input logic ov, input logic sy);
        @(negedge clk);
        src_sel = s; cd = d; over = ov; sync_mode = sy;
    endtask

    // measures the gap between consecutive pulses over a window
    task automatic measure(input int sgap, input int bgap, input int win,
                           input string sreq, input string breq);
        int last_s, last_b, ns, nb, bad_s, bad_b, act_s, act_b;
        last_s = -1; last_b = -1; ns = 0; nb = 0;
        bad_s = 0; bad_b = 0; act_s = sgap; act_b = bgap;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (samp_tick) begin
                if (last_s >= 0 && i - last_s != sgap) begin bad_s++; act_s = i - last_s; end
                last_s = i; ns++;
            end
            if (baud_tick) begin
                if (last_b >= 0 && i - last_b != bgap) begin bad_b++; act_b = i - last_b; end
                if (!samp_tick) bad_b++;
                last_b = i; nb++;
            end
        end
        check(bad_s == 0, sreq, act_s, sgap);
        check(ns >= 3, sreq, ns, 3);
        check(bad_b == 0, breq, act_b, bgap);
        check(nb >= 3, breq, nb, 3);
    endtask

    task automatic count_quiet(input int win, input string req);
        int n;
        n = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (samp_tick || baud_tick) n++;
        end
        check(n == 0, req, n, 0);
    endtask

    // first pulse offsets after a configuration change (applied at a negedge)
    task automatic first_offsets(input int exp_s, input int exp_b, input string req);
        int fs, fb;
        fs = -1; fb = -1;
        for (int i = 1; i <= exp_b + 4; i++) begin
            @(negedge clk);
            if (samp_tick && fs < 0) fs = i;
            if (baud_tick && fb < 0) fb = i;
        end
        check(fs == exp_s, req, fs, exp_s);
        check(fb == exp_b, req, fb, exp_b);
    endtask

    initial begin
        int base, sg, bg;
        string sreq, breq;
        logic [1:0] sels [3];
        logic [15:0] cds [3];
        sels = '{2'd0, 2'd1, 2'd3};
        cds  = '{16'd1, 16'd2, 16'd5};

        // R10: outputs held low in reset even with an active setting
        src_sel = 2'd0; cd = 16'd1;
        repeat (5) begin
            @(negedge clk);
            check(!samp_tick && !baud_tick, "R10", samp_tick + baud_tick, 0);
        end
        @(negedge clk);
        cd = 16'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R4: divisor zero stays idle
        count_quiet(300, "R4");

        // R6: reserved select stays idle
        set_cfg(2'd2, 16'd3, 1'b1, 1'b0);
        count_quiet(300, "R6");
        set_cfg(2'd2, 16'd1, 1'b0, 1'b1);
        count_quiet(200, "R6");

        // sweep: source x divisor x oversampling x mode
        foreach (sels[si]) begin
            foreach (cds[ci]) begin
                for (int ov = 0; ov < 2; ov++) begin
                    for (int sy = 0; sy < 2; sy++) begin
                        base = (sels[si] == 2'd0) ? 1 : (sels[si] == 2'd1) ? 8 : 6;
                        sg = base * int'(cds[ci]);
                        bg = (sy != 0) ? sg : sg * ((ov != 0) ? 8 : 16);
                        sreq = (sels[si] == 2'd0) ? "R1" : (sels[si] == 2'd1) ? "R2" : "R3";
                        if (cds[ci] == 16'd1) sreq = {sreq, "/R5"};
                        breq = (sy != 0) ? "R8" : "R7";
                        set_cfg(sels[si], cds[ci], ov[0], sy[0]);
                        measure(sg, bg, 4 * bg + 20, sreq, breq);
                    end
                end
            end
        end

        // R9: new divisor restarts phase
        set_cfg(2'd0, 16'd4, 1'b1, 1'b0);
        repeat (37) @(negedge clk);
        set_cfg(2'd0, 16'd6, 1'b1, 1'b0);
        first_offsets(6, 48, "R9");

        // R9: oversampling change restarts the post-divider
        set_cfg(2'd0, 16'd1, 1'b0, 1'b0);
        repeat (21) @(negedge clk);
        set_cfg(2'd0, 16'd1, 1'b1, 1'b0);
        first_offsets(1, 8, "R9");

        // R9: source change restarts the prescaler
        set_cfg(2'd0, 16'd3, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        set_cfg(2'd1, 16'd3, 1'b0, 1'b0);
        first_offsets(24, 384, "R9");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule